// File: doc/BRIEF.md
# Timer DMA Burst Register Window

This block lets a DMA engine reprogram a run of a timer's internal registers through one fixed bus address. Software sets a start register index and a burst length in a configuration register, and sets per-event DMA enable bits. When an enabled internal event fires, the block raises a DMA request. Each bus access to the window address acknowledges the current request and is forwarded to the next register of the run. After the last transfer the block goes idle.

The window holds no data of its own. Reads and writes through it reach the target bank register, which can also be reached directly at its own address. An event that arrives during a burst is remembered and starts a fresh burst from the start index once the current burst ends. Register indices past the end of the bank wrap back to index 0.

Top module: `timer_dma_burst`

## Requirements
- R1: Bus map (byte addresses). Bank register k is at 4*k for k = 0..7. The configuration register is at 0x40, the event-enable register at 0x44 and the window at 0x48. Reads of the bank, configuration and enable registers return the stored values. `bus_ready` equals `bus_sel`, so every access completes in one cycle.
- R2: The configuration register holds the start index in bits [2:0] and the burst length field in bits [11:8]. The enable register holds one DMA enable per event in bits [3:0]. Bit i enables event `evt_in[i]`.
- R3: A burst started with length field N raises exactly N+1 DMA requests. A field of 0 gives exactly one request. `dma_req` rises in the cycle after the clock edge that samples the enabled event.
- R4: The k-th window access of a burst (k from 0) reads or writes bank register (start + k) mod 8. A write through the window is visible at that register's direct address.
- R5: An event whose enable bit is clear raises no request.
- R6: `dma_req` stays high until a window access is made. It is low in the cycle after that access. If more transfers remain, it rises again one cycle later.
- R7: An enabled event that arrives during a burst is held as pending. When the current burst ends, a new burst of N+1 requests starts with its pointer back at the start index.
- R8: A window access made while no burst is active reaches the register at the start index.
- R9: Register indices wrap modulo 8, so a burst never targets a register outside the bank.
- R10: After reset, all bank registers, the configuration register and the enable register read 0, and `dma_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_ready | output | 1 | Access complete |
| evt_in | input | 4 | Internal event pulses |
| dma_req | output | 1 | DMA request, cleared by a window access |

## Verification
The bench sweeps every start index against every burst length from 0 to 7. A design with an off-by-one burst count would show one request too many or too few. A design that steps the pointer wrongly, or fails to wrap it, would leave the wrong bank words changed. Other tests hold a request without acknowledging it, which catches a design that drops the request on its own, and re-trigger during a burst, which catches a design that loses the pending event or restarts the burst from the wrong index. The bench also checks disabled events and window accesses outside a burst, where a design that misroutes the access would write the wrong register.

// File: rtl/timer_dma_burst.sv
module timer_dma_burst #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NUM_REGS = 8,
  parameter int NUM_EVT = 4,
  parameter int LEN_W = 4,
  parameter logic [7:0] CFG_ADDR = 8'h40,
  parameter logic [7:0] EN_ADDR = 8'h44,
  parameter logic [7:0] WIN_ADDR = 8'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic              dma_req
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int LEN_LSB = 8;
  localparam logic [ADDR_W-1:0] BANK_END = ADDR_W'(NUM_REGS * 4);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP} st_t;

  logic [DATA_W-1:0]  bank [NUM_REGS];
  logic [IDX_W-1:0]   start_q;
  logic [LEN_W-1:0]   len_q;
  logic [NUM_EVT-1:0] en_q;
  logic [LEN_W-1:0]   cnt;
  logic               pend;
  st_t                st;

  wire win_hit  = bus_sel && (bus_addr == ADDR_W'(WIN_ADDR));
  wire cfg_hit  = bus_sel && (bus_addr == ADDR_W'(CFG_ADDR));
  wire en_hit   = bus_sel && (bus_addr == ADDR_W'(EN_ADDR));
  wire bank_hit = bus_sel && (bus_addr < BANK_END) && (bus_addr[1:0] == 2'b00);
  wire trig     = |(evt_in & en_q);
  wire ack      = win_hit && (st == S_REQ);

  wire [IDX_W-1:0] dir_idx = bus_addr[IDX_W+1:2];
  wire [IDX_W-1:0] target  = (st == S_IDLE) ? start_q : start_q + IDX_W'(cnt);
  wire [IDX_W-1:0] wr_idx  = win_hit ? target : dir_idx;
  wire             bank_we = bus_wr && (win_hit || bank_hit);

  assign bus_ready = bus_sel;
  assign dma_req   = (st == S_REQ);

  always_comb begin
    bus_rdata = '0;
    if (win_hit)       bus_rdata = bank[target];
    else if (bank_hit) bus_rdata = bank[dir_idx];
    else if (cfg_hit) begin
      bus_rdata[IDX_W-1:0] = start_q;
      bus_rdata[LEN_LSB +: LEN_W] = len_q;
    end
    else if (en_hit)   bus_rdata[NUM_EVT-1:0] = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (bank_we) begin
      bank[wr_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
      en_q    <= '0;
    end else if (bus_wr) begin
      if (cfg_hit) begin
        start_q <= bus_wdata[IDX_W-1:0];
        len_q   <= bus_wdata[LEN_LSB +: LEN_W];
      end
      if (en_hit) en_q <= bus_wdata[NUM_EVT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      pend <= (st == S_IDLE) ? 1'b0 : (pend | trig);
      case (st)
        S_IDLE: if (trig || pend) begin
          st  <= S_REQ;
          cnt <= '0;
        end
        S_REQ: if (ack) begin
          if (cnt == len_q) st <= S_IDLE;
          else begin
            cnt <= cnt + 1'b1;
            st  <= S_GAP;
          end
        end
        S_GAP: st <= S_REQ;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !win_hit) |=> dma_req);

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && win_hit) |=> !dma_req);

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && !pend && !trig) |=> !dma_req);

  p_pend_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && pend) |=> (dma_req && cnt == '0));

  p_win_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && bus_wr) |=> (bank[$past(target)] == $past(bus_wdata)));
endmodule

// File: tb/timer_dma_burst_test.sv
`timescale 1ns/1ps
module timer_dma_burst_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [3:0]  evt_in = '0;
  logic        dma_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] model [8];

  localparam logic [7:0] CFG = 8'h40, EN = 8'h44, WIN = 8'h48;

  timer_dma_burst uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .evt_in(evt_in), .dma_req(dma_req)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] e);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic bank_check(input string req);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), d);
      chk(d == model[i], req, d, model[i]);
    end
  endtask

  // Serves requests until none appears; returns the number served.
  task automatic serve(input int start, input int len, input int base, input bit use_read, output int n);
    logic [31:0] d;
    int idx;
    n = 0;
    forever begin
      for (int w = 0; w < 4 && !dma_req; w++) @(negedge clk);
      if (!dma_req || n >= 64) break;
      idx = (start + (n % (len + 1))) % 8;
      if (use_read) begin
        rd(WIN, d);
        chk(d == model[idx], "R4 window read", d, model[idx]);
      end else begin
        d = 32'(base + n);
        wr(WIN, d);
        model[idx] = d;
      end
      n++;
      chk(dma_req == 1'b0, "R6 drop after access", 32'(dma_req), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(dma_req == 1'b0, "R10 req after reset", 32'(dma_req), 0);
    rd(CFG, d); chk(d == 0, "R10 cfg reset", d, 0);
    rd(EN, d);  chk(d == 0, "R10 en reset", d, 0);
    bank_check("R10 bank reset");

    // R1 R2 register readback and ready
    chk(bus_ready == 1'b0, "R1 ready idle", 32'(bus_ready), 0);
    bus_sel = 1'b1; bus_addr = CFG; #1;
    chk(bus_ready == 1'b1, "R1 ready on access", 32'(bus_ready), 1);
    @(negedge clk); bus_sel = 1'b0;
    wr(CFG, 32'h0000_0A05);
    rd(CFG, d); chk(d == 32'h0000_0A05, "R2 cfg fields", d, 32'h0A05);
    wr(EN, 32'h0000_0004);
    rd(EN, d); chk(d == 32'h4, "R2 enable field", d, 4);

    // R5 disabled event
    pulse(4'b0010);
    repeat (4) @(negedge clk);
    chk(dma_req == 1'b0, "R5 disabled event", 32'(dma_req), 0);

    // R3 latency, R6 hold without ack
    pulse(4'b0100);
    chk(dma_req == 1'b1, "R3 request after event", 32'(dma_req), 1);
    repeat (5) @(negedge clk);
    chk(dma_req == 1'b1, "R6 hold until access", 32'(dma_req), 1);
    serve(5, 10, 32'h7700, 1'b0, n);
    chk(n == 11, "R3 count len=10", 32'(n), 11);
    bank_check("R9 wrap len=10");

    // R8 idle window access
    wr(WIN, 32'h0000_0055); model[5] = 32'h55;
    rd(32'h14, d); chk(d == 32'h55, "R8 idle window write", d, 32'h55);
    rd(WIN, d); chk(d == 32'h55, "R8 idle window read", d, 32'h55);

    // R3 R4 R9 sweep of start x length
    wr(EN, 32'h1);
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 8; l++) begin
        bit use_read;
        use_read = (l % 3) == 2;
        wr(CFG, 32'(s | (l << 8)));
        pulse(4'b0001);
        serve(s, l, 32'hA000_0000 + ((s * 8 + l) << 8), use_read, n);
        chk(n == l + 1, "R3 request count", 32'(n), 32'(l + 1));
        bank_check("R4 R9 burst targets");
      end
    end

    // R7 re-trigger during burst restarts from start
    wr(CFG, 32'h0000_0206);
    pulse(4'b0001);
    chk(dma_req == 1'b1, "R7 first burst", 32'(dma_req), 1);
    pulse(4'b0001);
    serve(6, 2, 32'hB000_0000, 1'b0, n);
    chk(n == 6, "R7 pending burst count", 32'(n), 6);
    bank_check("R7 pending burst targets");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule